// File: doc/BRIEF.md
# Joinable Transmit/Receive Word FIFO Pair

This block holds two word queues between a bus side and an execution side. The transmit queue is filled by bus writes and drained by execution-side pulls. The receive queue is filled by execution-side pushes and drained by bus reads. One shared word store backs both queues. By default each queue owns half of it, which is four 32-bit words.

A two-bit join input can hand the whole store to one direction. That direction then holds eight words, and the other direction is switched off. Any change of the join input empties both queues. Each direction reports full, empty and an occupancy level.

An access the block cannot honour changes nothing. Examples are a write when full, a read when empty, or any access to a switched-off direction. Each such access raises a sticky error flag, which is cleared by a write-one-to-clear input. Read data is shown ahead: the word at the head of each queue is on its data output whenever the queue is not empty.

Top module: `jfifo_pair`

## Requirements
- R1: After reset both directions are empty and not full, both levels are 0, all error flags are 0, and the split is the unjoined one.
- R2: With join value 0, each direction holds 4 words in first-in first-out order and reports full at level 4.
- R3: With join value 1, the transmit queue holds 8 words. The receive direction then shows full=1, empty=1 and level 0, and refuses every push and read.
- R4: With join value 2, the receive queue holds 8 words. The transmit direction then shows full=1, empty=1 and level 0, and refuses every write and pull.
- R5: A bus write to a full transmit queue leaves its level and contents unchanged and sets error bit 0 (transmit overflow).
- R6: A bus read of an empty receive queue leaves it empty and sets error bit 3 (receive underflow). The data returned is not defined.
- R7: An execution-side pull of an empty transmit queue sets error bit 1 and changes nothing else. An execution-side push to a full receive queue is dropped and sets error bit 2.
- R8: In a cycle where the join input differs from its value in the previous cycle, both queues are emptied and every access in that cycle is ignored without raising an error.
- R9: A push and a pop in the same cycle on a queue that is neither empty nor full keep its level unchanged and preserve order.
- R10: Error flags stay set until a 1 is written to the matching bit of the clear input. A new error in the same cycle as its clear leaves the flag set.
- R11: Join value 3 behaves as join value 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| join_mode | input | 2 | 0 split, 1 all storage to transmit, 2 all storage to receive, 3 as 0 |
| tx_wr | input | 1 | Bus write into the transmit queue |
| tx_wdata | input | 32 | Word for the bus write |
| tx_pull | input | 1 | Execution side takes the transmit head |
| tx_rdata | output | 32 | Transmit head word |
| rx_push | input | 1 | Execution side adds a receive word |
| rx_wdata | input | 32 | Word for the receive push |
| rx_rd | input | 1 | Bus read of the receive head |
| rx_rdata | output | 32 | Receive head word |
| err_clr | input | 4 | Write-one-to-clear for the error flags |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| tx_level | output | 4 | Transmit occupancy 0..8 |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| rx_level | output | 4 | Receive occupancy 0..8 |
| err_flags | output | 4 | Sticky: 0 tx overflow, 1 tx underflow, 2 rx overflow, 3 rx underflow |

## Verification
The queues are filled to capacity under each join value and then drained with distinct words. This exposes wrong depth, a wrong base address in the shared store, and broken wrap-around. Accesses past full and empty, and accesses to a switched-off direction, show whether a refused access touches any state and whether it raises the right flag.

A join change is made with words still queued and with an access in the same cycle, which checks the flush. A write and a pull in one cycle separate a correct level update from one that counts only one side. Clearing a flag in the same cycle as a new error of that kind checks that the new error wins.

// File: rtl/jfifo_pair_pkg.sv
package jfifo_pair_pkg;
  typedef enum logic [1:0] {
    JOIN_SPLIT = 2'd0,
    JOIN_TX    = 2'd1,
    JOIN_RX    = 2'd2,
    JOIN_ALT   = 2'd3
  } join_e;

  localparam int ERR_TX_OVER  = 0;
  localparam int ERR_TX_UNDER = 1;
  localparam int ERR_RX_OVER  = 2;
  localparam int ERR_RX_UNDER = 3;
endpackage

// File: rtl/jfifo_ptrs.sv
module jfifo_ptrs #(
  parameter int TOTAL_WORDS = 8,
  localparam int AW = $clog2(TOTAL_WORDS),
  localparam int LW = $clog2(TOTAL_WORDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] cap,
  input  logic          flush,
  input  logic          push_req,
  input  logic          pop_req,
  output logic [AW-1:0] wr_idx,
  output logic [AW-1:0] rd_idx,
  output logic [LW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          push_ok,
  output logic          pop_ok,
  output logic          push_err,
  output logic          pop_err
);
  logic [AW-1:0] wr_d, rd_d;
  logic [LW-1:0] cnt_d;
  logic          upd;

  assign full     = (cap == '0) || (count == cap);
  assign empty    = (cap == '0) || (count == '0);
  assign push_ok  = push_req && !full && !flush;
  assign pop_ok   = pop_req && !empty && !flush;
  assign push_err = push_req && full && !flush;
  assign pop_err  = pop_req && empty && !flush;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] i, input logic [LW-1:0] c);
    return (LW'(i) == c - LW'(1)) ? '0 : i + AW'(1);
  endfunction

  always_comb begin
    wr_d  = wr_idx;
    rd_d  = rd_idx;
    cnt_d = count;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (push_ok) wr_d = step(wr_idx, cap);
      if (pop_ok)  rd_d = step(rd_idx, cap);
      if (push_ok && !pop_ok) cnt_d = count + LW'(1);
      if (pop_ok && !push_ok) cnt_d = count - LW'(1);
    end
  end

  assign upd = flush || push_ok || pop_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx <= '0;
      rd_idx <= '0;
      count  <= '0;
    end else if (upd) begin
      wr_idx <= wr_d;
      rd_idx <= rd_d;
      count  <= cnt_d;
    end
  end

  // R2: level never exceeds the granted capacity
  a_r2_level_in_cap: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> (count <= cap) || $changed(cap));
  // R9: simultaneous accepted push and pop holds the level
  a_r9_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_ok) |=> (count == $past(count)));
  // R8: flush empties the queue
  a_r8_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));
  // R5: refused push alone leaves the level alone
  a_r5_refused_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (push_err && !pop_ok) |=> $stable(count));
endmodule

// File: rtl/jfifo_store.sv
module jfifo_store #(
  parameter int WORD_W      = 32,
  parameter int TOTAL_WORDS = 8,
  localparam int AW = $clog2(TOTAL_WORDS)
) (
  input  logic              clk,
  input  logic              we_a,
  input  logic [AW-1:0]     wa_a,
  input  logic [WORD_W-1:0] wd_a,
  input  logic              we_b,
  input  logic [AW-1:0]     wa_b,
  input  logic [WORD_W-1:0] wd_b,
  input  logic [AW-1:0]     ra_a,
  input  logic [AW-1:0]     ra_b,
  output logic [WORD_W-1:0] rd_a,
  output logic [WORD_W-1:0] rd_b
);
  logic [WORD_W-1:0] mem [TOTAL_WORDS];

  always_ff @(posedge clk) begin
    if (we_a) mem[wa_a] <= wd_a;
    if (we_b) mem[wa_b] <= wd_b;
  end

  assign rd_a = mem[ra_a];
  assign rd_b = mem[ra_b];

  // the two queues own disjoint regions, so writes never collide
  a_r2_no_collide: assert property (@(posedge clk) !(we_a && we_b && (wa_a == wa_b)));
endmodule

// File: rtl/jfifo_pair.sv
module jfifo_pair
  import jfifo_pair_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int TOTAL_WORDS = 8,
  localparam int AW   = $clog2(TOTAL_WORDS),
  localparam int LW   = $clog2(TOTAL_WORDS + 1),
  localparam int HALF = TOTAL_WORDS / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        join_mode,
  input  logic              tx_wr,
  input  logic [WORD_W-1:0] tx_wdata,
  input  logic              tx_pull,
  output logic [WORD_W-1:0] tx_rdata,
  input  logic              rx_push,
  input  logic [WORD_W-1:0] rx_wdata,
  input  logic              rx_rd,
  output logic [WORD_W-1:0] rx_rdata,
  input  logic [3:0]        err_clr,
  output logic              tx_full,
  output logic              tx_empty,
  output logic [LW-1:0]     tx_level,
  output logic              rx_full,
  output logic              rx_empty,
  output logic [LW-1:0]     rx_level,
  output logic [3:0]        err_flags
);
  logic [1:0]    join_q;
  logic          flush;
  logic [LW-1:0] tx_cap, rx_cap;
  logic [AW-1:0] rx_base;
  logic [AW-1:0] tx_wi, tx_ri, rx_wi, rx_ri;
  logic          tx_pok, tx_qok, tx_perr, tx_qerr;
  logic          rx_pok, rx_qok, rx_perr, rx_qerr;
  logic [3:0]    err_set, err_d;

  assign flush = (join_mode != join_q);

  always_comb begin
    tx_cap  = LW'(HALF);
    rx_cap  = LW'(HALF);
    rx_base = AW'(HALF);
    case (join_e'(join_q))
      JOIN_TX: begin tx_cap = LW'(TOTAL_WORDS); rx_cap = '0; end
      JOIN_RX: begin tx_cap = '0; rx_cap = LW'(TOTAL_WORDS); rx_base = '0; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     join_q <= JOIN_SPLIT;
    else if (flush) join_q <= join_mode;
  end

  jfifo_ptrs #(.TOTAL_WORDS(TOTAL_WORDS)) u_tx_ptrs (
    .clk(clk), .rst_n(rst_n), .cap(tx_cap), .flush(flush),
    .push_req(tx_wr), .pop_req(tx_pull),
    .wr_idx(tx_wi), .rd_idx(tx_ri), .count(tx_level),
    .full(tx_full), .empty(tx_empty),
    .push_ok(tx_pok), .pop_ok(tx_qok), .push_err(tx_perr), .pop_err(tx_qerr)
  );

  jfifo_ptrs #(.TOTAL_WORDS(TOTAL_WORDS)) u_rx_ptrs (
    .clk(clk), .rst_n(rst_n), .cap(rx_cap), .flush(flush),
    .push_req(rx_push), .pop_req(rx_rd),
    .wr_idx(rx_wi), .rd_idx(rx_ri), .count(rx_level),
    .full(rx_full), .empty(rx_empty),
    .push_ok(rx_pok), .pop_ok(rx_qok), .push_err(rx_perr), .pop_err(rx_qerr)
  );

  jfifo_store #(.WORD_W(WORD_W), .TOTAL_WORDS(TOTAL_WORDS)) u_store (
    .clk(clk),
    .we_a(tx_pok), .wa_a(tx_wi), .wd_a(tx_wdata),
    .we_b(rx_pok), .wa_b(rx_base + rx_wi), .wd_b(rx_wdata),
    .ra_a(tx_ri), .ra_b(rx_base + rx_ri),
    .rd_a(tx_rdata), .rd_b(rx_rdata)
  );

  always_comb begin
    err_set               = '0;
    err_set[ERR_TX_OVER]  = tx_perr;
    err_set[ERR_TX_UNDER] = tx_qerr;
    err_set[ERR_RX_OVER]  = rx_perr;
    err_set[ERR_RX_UNDER] = rx_qerr;
    err_d = (err_flags & ~err_clr) | err_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_flags <= '0;
    else        err_flags <= err_d;
  end

  // R3: receive direction is switched off while storage is joined to transmit
  a_r3_rx_off: assert property (@(posedge clk) disable iff (!rst_n)
    (join_q == JOIN_TX) |-> (rx_full && rx_empty && rx_level == '0));
  // R4: transmit direction is switched off while storage is joined to receive
  a_r4_tx_off: assert property (@(posedge clk) disable iff (!rst_n)
    (join_q == JOIN_RX) |-> (tx_full && tx_empty && tx_level == '0));
  // R5: write into a full transmit queue raises the overflow flag
  a_r5_tx_over_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && tx_full && !flush) |=> err_flags[ERR_TX_OVER]);
  // R6: read of an empty receive queue raises the underflow flag
  a_r6_rx_under_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && rx_empty && !flush) |=> err_flags[ERR_RX_UNDER]);
  // R10: flags hold until cleared
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flags[ERR_TX_UNDER] && !err_clr[ERR_TX_UNDER]) |=> err_flags[ERR_TX_UNDER]);
endmodule

// File: tb/jfifo_pair_tb.sv
module jfifo_pair_tb;
  logic        clk, rst_n;
  logic [1:0]  join_mode;
  logic        tx_wr, tx_pull, rx_push, rx_rd;
  logic [31:0] tx_wdata, rx_wdata, tx_rdata, rx_rdata;
  logic [3:0]  err_clr, err_flags;
  logic        tx_full, tx_empty, rx_full, rx_empty;
  logic [3:0]  tx_level, rx_level;

  int errors = 0, checks = 0;
  logic [31:0] txq[$], rxq[$];
  logic [3:0]  exp_err = 0;
  logic [1:0]  cur_join = 0;
  bit          done = 0;

  jfifo_pair u_dut (.*);

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int capof(input logic [1:0] j, input bit is_tx);
    if (j == 2'd1) return is_tx ? 8 : 0;
    if (j == 2'd2) return is_tx ? 0 : 8;
    return 4;
  endfunction

  task automatic check_state(input string tag);
    int tc = capof(cur_join, 1), rc = capof(cur_join, 0);
    chk({tag, " tx_level"}, 32'(tx_level), 32'(txq.size()));
    chk({tag, " rx_level"}, 32'(rx_level), 32'(rxq.size()));
    chk({tag, " tx_full"},  32'(tx_full),  32'(txq.size() == tc));
    chk({tag, " tx_empty"}, 32'(tx_empty), 32'(txq.size() == 0));
    chk({tag, " rx_full"},  32'(rx_full),  32'(rxq.size() == rc));
    chk({tag, " rx_empty"}, 32'(rx_empty), 32'(rxq.size() == 0));
    chk({tag, " err"},      32'(err_flags), 32'(exp_err));
  endtask

  // driver: one cycle of stimulus, expected queue updated; monitor compares heads
  task automatic op(input string tag, input logic [1:0] j,
                    input bit wr, input logic [31:0] wd, input bit pull,
                    input bit push, input logic [31:0] pd, input bit rd,
                    input logic [3:0] clr);
    bit chg = (j != cur_join);
    int tc = capof(cur_join, 1), rc = capof(cur_join, 0);
    logic [3:0] ne = 0;
    join_mode = j; tx_wr = wr; tx_wdata = wd; tx_pull = pull;
    rx_push = push; rx_wdata = pd; rx_rd = rd; err_clr = clr;
    if (chg) begin
      txq.delete(); rxq.delete();
    end else begin
      bit tf = (txq.size() == tc), te = (txq.size() == 0);
      bit rf = (rxq.size() == rc), re = (rxq.size() == 0);
      if (pull && !te) begin chk({tag, " tx head"}, tx_rdata, txq[0]); void'(txq.pop_front()); end
      if (pull && te) ne[1] = 1;
      if (wr && !tf) txq.push_back(wd);
      if (wr && tf) ne[0] = 1;
      if (rd && !re) begin chk({tag, " rx head"}, rx_rdata, rxq[0]); void'(rxq.pop_front()); end
      if (rd && re) ne[3] = 1;
      if (push && !rf) rxq.push_back(pd);
      if (push && rf) ne[2] = 1;
    end
    exp_err = (exp_err & ~clr) | ne;
    @(posedge clk); @(negedge clk);
    cur_join = j;
    tx_wr = 0; tx_pull = 0; rx_push = 0; rx_rd = 0; err_clr = 0;
    check_state(tag);
  endtask

  initial begin
    #(10ns * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; join_mode = 0; tx_wr = 0; tx_pull = 0; rx_push = 0; rx_rd = 0;
    tx_wdata = 0; rx_wdata = 0; err_clr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_state("R1 reset");

    // R2 split: 4 deep each, order preserved
    for (int i = 0; i < 4; i++) op("R2 tx fill", 0, 1, 32'hA000 + i, 0, 0, 0, 0, 0);
    op("R5 tx overflow", 0, 1, 32'hDEAD, 0, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) op("R2 tx drain", 0, 0, 0, 1, 0, 0, 0, 0);
    op("R7 tx underflow", 0, 0, 0, 1, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) op("R2 rx fill", 0, 0, 0, 0, 1, 32'hB000 + i, 0, 0);
    op("R7 rx overflow", 0, 0, 0, 0, 1, 32'hBEEF, 0, 0);
    for (int i = 0; i < 4; i++) op("R2 rx drain", 0, 0, 0, 0, 0, 0, 1, 0);
    op("R6 rx underflow", 0, 0, 0, 0, 0, 0, 1, 0);

    // R10 clear and set-beats-clear
    op("R10 clear bit0", 0, 0, 0, 0, 0, 0, 0, 4'b0001);
    op("R10 idle hold", 0, 0, 0, 0, 0, 0, 0, 0);
    op("R10 set beats clear", 0, 0, 0, 1, 0, 0, 0, 4'b0010);
    op("R10 clear all", 0, 0, 0, 0, 0, 0, 0, 4'b1111);

    // R9 simultaneous push/pop
    op("R9 pre", 0, 1, 32'h11, 0, 1, 32'h21, 0, 0);
    op("R9 pre", 0, 1, 32'h12, 0, 1, 32'h22, 0, 0);
    op("R9 both", 0, 1, 32'h13, 1, 1, 32'h23, 1, 0);
    op("R9 both", 0, 1, 32'h14, 1, 1, 32'h24, 1, 0);

    // R8 join change with data pending and an access in the change cycle
    op("R8 flush", 1, 1, 32'h77, 0, 1, 32'h78, 0, 0);

    // R3 transmit joined to 8
    for (int i = 0; i < 8; i++) op("R3 tx fill", 1, 1, 32'hC000 + i, 0, 0, 0, 0, 0);
    op("R3 rx push refused", 1, 0, 0, 0, 1, 32'h99, 0, 0);
    op("R3 rx read refused", 1, 0, 0, 0, 0, 0, 1, 0);
    for (int i = 0; i < 8; i++) op("R3 tx drain", 1, 0, 0, 1, 0, 0, 0, 0);
    op("R3 clear", 1, 0, 0, 0, 0, 0, 0, 4'b1111);

    // R4 receive joined to 8
    op("R8 to rx join", 2, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) op("R4 rx fill", 2, 0, 0, 0, 1, 32'hD000 + i, 0, 0);
    op("R4 tx write refused", 2, 1, 32'h55, 0, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) op("R4 rx drain", 2, 0, 0, 0, 0, 0, 1, 0);
    op("R4 clear", 2, 0, 0, 0, 0, 0, 0, 4'b1111);

    // R11 value 3 acts as split
    op("R11 enter", 3, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) op("R11 tx fill", 3, 1, 32'hE000 + i, 0, 1, 32'hF000 + i, 0, 0);
    for (int i = 0; i < 4; i++) op("R11 drain", 3, 0, 0, 1, 0, 0, 1, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule